// File: doc/BRIEF.md
# LCD Segment Scan Memory

This block keeps a small byte-wide display memory for a multiplexed LCD and scans it continuously with no help from the CPU. The CPU reads and writes the memory through a plain bus: address, write data, write strobe and read data. Every byte carries two segments, one per nibble. The position of a bit inside a nibble names the common phase that the bit belongs to. On each phase the block raises exactly one common output. For every segment it presents a 1 (select, segment on) or a 0 (deselect, segment off).

The duty mode sets how many commons are scanned: two, three or four. A programmable divider sets how fast the commons step. The upper segment pins fall into three groups, and each group can be released from LCD use. A released group shows deselect on all its segments and drops its enable output, while its memory stays ordinary storage. Analog bias levels and pad drivers lie outside the block. The registered duty mode resets to the four-common setting.

Top module: `lcd_seg_scan`

## Requirements
- R1: Byte addresses 0x64 to 0x78 (21 bytes) hold display data. A write with `bus_we` high stores `bus_wdata` at the next clock edge. `bus_rdata` shows the byte at `bus_addr` combinationally.
- R2: A write to any address outside 0x64 to 0x78 changes no stored byte. A read at such an address returns 0.
- R3: Segment 2n takes bits 3..0 of byte 0x64+n, and segment 2n+1 takes bits 7..4. During phase k, `seg_out[s]` equals bit k of that segment's nibble, where 1 means select.
- R4: `com_out` is one-hot at all times. Bit k of `com_out` is high during phase k.
- R5: `cfg_duty` selects the mode: 0 scans COM0 and COM1, 1 scans COM0 to COM2, and 2 or 3 scan COM0 to COM3. The phase steps upward and wraps to COM0 after the last common of the mode.
- R6: The phase advances once every `scan_div`+1 clock cycles.
- R7: A change of `cfg_duty` returns the phase to COM0 and restarts the divider at the clock edge that first sees the new value.
- R8: `cfg_release` bit 0 releases SEG20–27, bit 1 releases SEG28–35 and bit 2 releases SEG36–41, one clock edge after it is sampled. The released segments output 0 and the matching `grp_lcd_en` bit is low. The group's bytes remain readable and writable.
- R9: While reset is asserted, every byte reads 0, `com_out` is COM0, `seg_out` is 0 and `grp_lcd_en` is all ones, whatever the configuration inputs are.
- R10: A write to a byte that the current phase uses appears on `seg_out` in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data |
| cfg_duty | input | 2 | Duty mode select |
| cfg_release | input | 3 | Per-group release to general use |
| scan_div | input | 8 | Phase divider; period is scan_div+1 cycles |
| com_out | output | 4 | One-hot common phase |
| seg_out | output | 42 | Per-segment select (1) / deselect (0) |
| grp_lcd_en | output | 3 | High while the group is in LCD use |

## Verification
The phase properties assume that `cfg_duty` was stable over the previous edge. This is how they tie the range of the common to the mode that the block has registered. The checks on released groups assume that the group's enable output and its segments change at the same edge. The stimulus changes configuration and bus inputs only on the falling clock edge and holds them steady across each rising edge. It holds `cfg_duty` steady at the release of reset, so no duty change is seen in the first cycle after reset.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int unsigned NUM_COMS = 4;
    localparam int unsigned PH_W     = 2;

    typedef enum logic [1:0] {
        DUTY_TWO   = 2'b00,
        DUTY_THREE = 2'b01,
        DUTY_FOUR  = 2'b10,
        DUTY_FOURB = 2'b11
    } duty_e;

    function automatic logic [PH_W-1:0] last_phase(input logic [1:0] duty);
        case (duty_e'(duty))
            DUTY_TWO:   return 2'd1;
            DUTY_THREE: return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/lcd_dram.sv
module lcd_dram #(
    parameter int unsigned AW     = 8,
    parameter logic [7:0]  BASE   = 8'h64,
    parameter int unsigned NBYTES = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic [7:0]            wdata,
    input  logic                  we,
    output logic [7:0]            rdata,
    output logic [NBYTES*8-1:0]   mem_flat
);

    typedef struct packed {
        logic [NBYTES-1:0][7:0] mem;
    } dram_st_t;

    dram_st_t st_d, st_q;
    logic [AW-1:0] offs;
    logic          hit;

    assign offs = addr - AW'(BASE);
    assign hit  = (offs < AW'(NBYTES));

    always_comb begin
        st_d  = st_q;
        rdata = 8'h00;
        for (int i = 0; i < int'(NBYTES); i++) begin
            if (hit && (offs == AW'(i))) begin
                rdata = st_q.mem[i];
                if (we) begin
                    st_d.mem[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_flat = st_q.mem;

endmodule

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen
    import lcd_scan_pkg::*;
#(
    parameter int unsigned PRESC_W = 8,
    parameter int unsigned NGRP    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_duty,
    input  logic [NGRP-1:0]    cfg_release,
    input  logic [PRESC_W-1:0] scan_div,
    output logic [PH_W-1:0]    phase,
    output logic [NGRP-1:0]    released
);

    typedef struct packed {
        logic [1:0]         duty;
        logic [NGRP-1:0]    rel;
        logic [PRESC_W-1:0] cnt;
        logic [PH_W-1:0]    ph;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.duty = cfg_duty;
        st_d.rel  = cfg_release;
        if (cfg_duty != st_q.duty) begin
            st_d.cnt = '0;
            st_d.ph  = '0;
        end else if (st_q.cnt >= scan_div) begin
            st_d.cnt = '0;
            st_d.ph  = (st_q.ph >= last_phase(st_q.duty)) ? '0 : st_q.ph + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.duty <= DUTY_FOUR;
            st_q.rel  <= '0;
            st_q.cnt  <= '0;
            st_q.ph   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.ph;
    assign released = st_q.rel;

endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
    import lcd_scan_pkg::*;
#(
    parameter int unsigned NSEG   = 42,
    parameter int unsigned NBYTES = 21,
    parameter int unsigned NGRP   = 3,
    parameter int unsigned G0_LO  = 20,
    parameter int unsigned G1_LO  = 28,
    parameter int unsigned G2_LO  = 36
) (
    input  logic [NBYTES*8-1:0] mem_flat,
    input  logic [PH_W-1:0]     phase,
    input  logic [NGRP-1:0]     released,
    output logic [NSEG-1:0]     seg_out
);

    function automatic int grp_of(input int s);
        if (s >= int'(G2_LO)) return 2;
        if (s >= int'(G1_LO)) return 1;
        if (s >= int'(G0_LO)) return 0;
        return -1;
    endfunction

    for (genvar s = 0; s < int'(NSEG); s++) begin : g_seg
        localparam int LSB = (s / 2) * 8 + (s % 2) * 4;
        localparam int GRP = grp_of(s);
        logic [NUM_COMS-1:0] nib;
        assign nib = mem_flat[LSB +: NUM_COMS];
        if (GRP < 0) begin : g_fixed
            assign seg_out[s] = nib[phase];
        end else begin : g_shared
            assign seg_out[s] = nib[phase] & ~released[GRP];
        end
    end

endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan
    import lcd_scan_pkg::*;
#(
    parameter int unsigned AW      = 8,
    parameter logic [7:0]  BASE    = 8'h64,
    parameter int unsigned NSEG    = 42,
    parameter int unsigned PRESC_W = 8,
    parameter int unsigned G0_LO   = 20,
    parameter int unsigned G1_LO   = 28,
    parameter int unsigned G2_LO   = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_we,
    output logic [7:0]          bus_rdata,
    input  logic [1:0]          cfg_duty,
    input  logic [2:0]          cfg_release,
    input  logic [PRESC_W-1:0]  scan_div,
    output logic [NUM_COMS-1:0] com_out,
    output logic [NSEG-1:0]     seg_out,
    output logic [2:0]          grp_lcd_en
);

    localparam int unsigned NBYTES = NSEG / 2;
    localparam int unsigned NGRP   = 3;

    logic [NBYTES*8-1:0] mem_flat;
    logic [PH_W-1:0]     phase;
    logic [NGRP-1:0]     released;

    lcd_dram #(.AW(AW), .BASE(BASE), .NBYTES(NBYTES)) u_dram (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .rdata    (bus_rdata),
        .mem_flat (mem_flat)
    );

    lcd_phase_gen #(.PRESC_W(PRESC_W), .NGRP(NGRP)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_duty    (cfg_duty),
        .cfg_release (cfg_release),
        .scan_div    (scan_div),
        .phase       (phase),
        .released    (released)
    );

    lcd_seg_map #(
        .NSEG(NSEG), .NBYTES(NBYTES), .NGRP(NGRP),
        .G0_LO(G0_LO), .G1_LO(G1_LO), .G2_LO(G2_LO)
    ) u_map (
        .mem_flat (mem_flat),
        .phase    (phase),
        .released (released),
        .seg_out  (seg_out)
    );

    assign com_out    = NUM_COMS'(1) << phase;
    assign grp_lcd_en = ~released;

endmodule

// File: rtl/lcd_seg_scan_chk.sv
module lcd_seg_scan_chk #(
    parameter int unsigned AW    = 8,
    parameter logic [7:0]  BASE  = 8'h64,
    parameter int unsigned NSEG  = 42,
    parameter int unsigned G0_LO = 20,
    parameter int unsigned G1_LO = 28,
    parameter int unsigned G2_LO = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic [7:0]      bus_rdata,
    input logic [1:0]      cfg_duty,
    input logic [3:0]      com_out,
    input logic [NSEG-1:0] seg_out,
    input logic [2:0]      grp_lcd_en
);

    localparam int unsigned LAST_ADDR = int'(BASE) + NSEG / 2 - 1;

    AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_out) == 1); // R4

    AST_COM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(com_out)) |->
            (com_out == 4'b0001 || com_out == ($past(com_out) << 1))); // R5

    AST_TWO_COM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_duty) == 2'b00) |-> com_out[3:2] == 2'b00); // R5

    AST_THREE_COM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_duty) == 2'b01) |-> !com_out[3]); // R5

    AST_DUTY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_duty != $past(cfg_duty)) |=> com_out == 4'b0001); // R7

    AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) < int'(BASE) || int'(bus_addr) > int'(LAST_ADDR)) |->
            bus_rdata == 8'h00); // R2

    AST_GRP0_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_lcd_en[0] |-> seg_out[G1_LO-1:G0_LO] == '0); // R8

    AST_GRP1_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_lcd_en[1] |-> seg_out[G2_LO-1:G1_LO] == '0); // R8

    AST_GRP2_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_lcd_en[2] |-> seg_out[NSEG-1:G2_LO] == '0); // R8

endmodule

bind lcd_seg_scan lcd_seg_scan_chk #(
    .AW(AW), .BASE(BASE), .NSEG(NSEG),
    .G0_LO(G0_LO), .G1_LO(G1_LO), .G2_LO(G2_LO)
) chk_i (.*);

// File: tb/lcd_seg_scan_tb_top.sv
module lcd_seg_scan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [1:0]  cfg_duty = 2'b10;
    logic [2:0]  cfg_release = 3'b111;
    logic [7:0]  scan_div = 8'd0;
    logic [3:0]  com_out;
    logic [41:0] seg_out;
    logic [2:0]  grp_lcd_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] mref [21];

    always #4 clk = ~clk;

    lcd_seg_scan dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata),
        .cfg_duty(cfg_duty), .cfg_release(cfg_release), .scan_div(scan_div),
        .com_out(com_out), .seg_out(seg_out), .grp_lcd_en(grp_lcd_en)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [41:0] exp_seg(input int p, input logic [2:0] rel);
        logic [41:0] v;
        for (int s = 0; s < 42; s++) begin
            logic [7:0] b;
            logic [3:0] nib;
            b      = mref[s / 2];
            nib    = (s % 2 == 1) ? b[7:4] : b[3:0];
            v[s]   = nib[p];
            if (s >= 20 && s <= 27 && rel[0]) v[s] = 1'b0;
            if (s >= 28 && s <= 35 && rel[1]) v[s] = 1'b0;
            if (s >= 36 && rel[2]) v[s] = 1'b0;
        end
        return v;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a >= 8'h64 && a <= 8'h78) mref[a - 8'h64] = d;
    endtask

    task automatic bus_read_chk(input logic [7:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a;
        #1;
        e = (a >= 8'h64 && a <= 8'h78) ? mref[a - 8'h64] : 8'h00;
        chk(bus_rdata == e, req, 64'(bus_rdata), 64'(e));
    endtask

    // Restart the scan through a duty change, then follow it step by step.
    task automatic run_scan(input logic [1:0] duty, input int div, input int steps,
                            input string req);
        int ncom;
        ncom = (duty == 2'b00) ? 2 : (duty == 2'b01) ? 3 : 4;
        @(negedge clk);
        scan_div = 8'(div);
        cfg_duty = (duty == 2'b00) ? 2'b01 : 2'b00;
        @(negedge clk);
        cfg_duty = duty;
        @(negedge clk);
        for (int i = 0; i < steps; i++) begin
            int p;
            p = (i / (div + 1)) % ncom;
            chk(com_out == 4'(1 << p), req, 64'(com_out), 64'(1 << p));
            chk(seg_out == exp_seg(p, cfg_release), req, 64'(seg_out),
                64'(exp_seg(p, cfg_release)));
            chk(grp_lcd_en == ~cfg_release, "R8", 64'(grp_lcd_en), 64'(~cfg_release));
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 21; i++) mref[i] = 8'h00;

        // R9: reset state while held, configuration inputs drive non-default values
        repeat (3) @(negedge clk);
        chk(com_out == 4'b0001, "R9", 64'(com_out), 64'h1);
        chk(seg_out == '0, "R9", 64'(seg_out), 64'h0);
        chk(grp_lcd_en == 3'b111, "R9", 64'(grp_lcd_en), 64'h7);
        cfg_release = 3'b000;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 8'h64; a <= 8'h78; a++) bus_read_chk(8'(a), "R9");

        // R1: fill every byte with a computed pattern and read it back
        for (int n = 0; n < 21; n++) bus_write(8'(8'h64 + n), 8'((n * 37 + 11) & 8'hFF));
        for (int n = 0; n < 21; n++) bus_read_chk(8'(8'h64 + n), "R1");

        // R2: writes outside the window are dropped, reads there return zero
        foreach (mref[i]) begin end
        bus_write(8'h63, 8'hFF);
        bus_write(8'h79, 8'hFF);
        bus_write(8'h00, 8'hA5);
        bus_write(8'hFF, 8'h5A);
        for (int a = 8'h60; a < 8'h64; a++) bus_read_chk(8'(a), "R2");
        for (int a = 8'h79; a < 8'h7D; a++) bus_read_chk(8'(a), "R2");
        bus_read_chk(8'hFF, "R2");
        for (int n = 0; n < 21; n++) bus_read_chk(8'(8'h64 + n), "R2");

        // R3 R4 R5 R6 R7: every duty code against several divider values
        for (int d = 0; d < 4; d++) begin
            run_scan(2'(d), 0, 16, "R5");
            run_scan(2'(d), 1, 20, "R6");
            run_scan(2'(d), 3, 36, "R3");
        end
        // R7: change duty mid-scan from a late phase
        run_scan(2'b10, 0, 3, "R7");
        run_scan(2'b00, 2, 12, "R7");

        // R8: every release combination, segment and enable outputs
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            cfg_release = 3'(r);
            run_scan(2'b10, 0, 8, "R8");
        end
        // R8: storage of released groups stays usable
        @(negedge clk);
        cfg_release = 3'b111;
        bus_write(8'h6E, 8'hC3);
        bus_write(8'h72, 8'h3C);
        bus_write(8'h78, 8'h96);
        bus_read_chk(8'h6E, "R8");
        bus_read_chk(8'h72, "R8");
        bus_read_chk(8'h78, "R8");
        @(negedge clk);
        cfg_release = 3'b000;
        run_scan(2'b10, 0, 8, "R8");

        // R10: write while the phase is parked on COM0, new data visible next cycle
        run_scan(2'b10, 200, 1, "R10");
        bus_write(8'h64, 8'h5A);
        chk(seg_out == exp_seg(0, 3'b000), "R10", 64'(seg_out), 64'(exp_seg(0, 3'b000)));
        bus_write(8'h78, 8'h01);
        chk(seg_out == exp_seg(0, 3'b000), "R10", 64'(seg_out), 64'(exp_seg(0, 3'b000)));
        bus_write(8'h78, 8'h10);
        chk(seg_out == exp_seg(0, 3'b000), "R10", 64'(seg_out), 64'(exp_seg(0, 3'b000)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule